// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small 32-bit integer processor organised as an in-order pipeline of five stages: fetch, decode, execute, memory access and writeback. It fetches one 32-bit instruction per cycle from an instruction memory port and reads or writes whole words through a data memory port. It keeps 32 general registers. Three instruction layouts are decoded: a register layout with three register fields and a 6-bit function code in its low bits, an immediate layout with two register fields and a 16-bit constant, and a jump layout with a 26-bit offset.

Results are forwarded from the later stages to the operands of the instruction in execute. A load that feeds the very next instruction costs one bubble. Branches and jumps are resolved one stage after execute, in the memory stage; when they are taken, the three younger instructions are discarded. Software therefore sees strictly sequential execution. Both memory ports read combinationally. The data port's address, write data and write strobe come straight from a pipeline register, and a loaded word is captured in a load-data register before writeback.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address becomes 0 and no data write is issued; on the first cycle after release the fetch address is still 0.
- R2: Without a stall or a taken control transfer, the fetch address grows by 4 each cycle.
- R3: Opcode 0x00 is the register layout: bits 25:21 first source, bits 20:16 second source, bits 15:11 destination, bits 5:0 function. The function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than, 0x04 shift left, 0x06 logical shift right and 0x07 arithmetic shift right. Shift amounts come from the low 5 bits of the second source. Any other function code writes nothing.
- R4: The immediate layout holds the opcode, then the source in bits 25:21, the target in bits 20:16 and the constant in bits 15:0. Opcode 0x08 adds and 0x0A does a signed set-less-than; both sign-extend the constant. Opcodes 0x0C and, 0x0D or and 0x0E xor zero-extend it.
- R5: Register 0 reads as zero. Writes to it have no effect, and it is never a forwarding source.
- R6: A result is used by the next instruction and by the one after it without waiting.
- R7: Opcode 0x23 loads the word at source plus the sign-extended constant into the target register. Opcode 0x2B stores the register in bits 20:16 at that address.
- R8: An instruction that reads a register loaded by the instruction directly before it gets the loaded value. This holds for ALU sources, store data and branch conditions. The pipeline inserts exactly one bubble for such a pair.
- R9: Opcode 0x04 branches when the register in bits 25:21 is zero and opcode 0x05 when it is non-zero. The target is the branch address plus 4 plus the sign-extended 16-bit constant.
- R10: When a branch or jump is taken, none of the three instructions fetched after it has any effect.
- R11: Opcode 0x02 jumps to its own address plus 4 plus the sign-extended 26-bit field in bits 25:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the data access in the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Write strobe for a store |
| dmem_rdata | input | 32 | Word at `dmem_addr`, same cycle |

## Verification
The bench runs a program whose results are written to data memory, and it checks the order and value of every store. One part stores from register 0 right after an immediate add that targets register 0. A core that forwarded from register 0 would store 7 there instead of 0. Loads are followed directly by an ALU use, by a store of the loaded register and by a branch on it. A missing interlock shows up as a stale operand, and a branch that tests that stale value would skip a store. A taken branch, a taken loop branch and a jump each jump over stores to an out-of-range address. A flush that lets a younger store through writes there, and a wrong target breaks the store order or the loop count. The zero-extended logical immediates and the arithmetic shift catch a core that sign-extends or shifts in the wrong way.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int ILEN   = 32;
  localparam int OPC_W  = 6;
  localparam int RIDX_W = 5;
  localparam int FUNC_W = 6;
  localparam int IMM_W  = 16;
  localparam int JOFF_W = 26;
  localparam int NREGS  = 1 << RIDX_W;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BZ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNZ  = 6'h05;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_XORI = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_LDW  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STW  = 6'h2B;

  localparam logic [FUNC_W-1:0] FN_SLL = 6'h04;
  localparam logic [FUNC_W-1:0] FN_SRL = 6'h06;
  localparam logic [FUNC_W-1:0] FN_SRA = 6'h07;
  localparam logic [FUNC_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNC_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNC_W-1:0] FN_XOR = 6'h26;
  localparam logic [FUNC_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_SLT, ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef enum logic [1:0] {
    CT_NONE, CT_BZ, CT_BNZ, CT_JMP
  } ctl_xfer_e;

  typedef enum logic [1:0] {
    FW_REG, FW_MEM, FW_WB
  } fwd_sel_e;

  typedef struct packed {
    logic      live;
    alu_op_e   op;
    logic      use_imm;
    logic      reg_we;
    logic      is_load;
    logic      is_store;
    ctl_xfer_e xfer;
    logic      rd_a;
    logic      rd_b;
  } ctrl_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              valid,
  input  logic [ILEN-1:0]   instr,
  output ctrl_t             ctrl,
  output logic [RIDX_W-1:0] src_a,
  output logic [RIDX_W-1:0] src_b,
  output logic [RIDX_W-1:0] dest,
  output logic [XLEN-1:0]   imm
);

  logic [OPC_W-1:0]  opc;
  logic [FUNC_W-1:0] fn;
  logic [IMM_W-1:0]  k16;
  logic [JOFF_W-1:0] k26;

  assign opc   = instr[31:26];
  assign fn    = instr[FUNC_W-1:0];
  assign k16   = instr[IMM_W-1:0];
  assign k26   = instr[JOFF_W-1:0];
  assign src_a = instr[25:21];
  assign src_b = instr[20:16];

  always_comb begin
    ctrl      = '0;
    ctrl.op   = ALU_ADD;
    ctrl.xfer = CT_NONE;
    dest      = instr[20:16];
    imm       = XLEN'($signed(k16));
    unique case (opc)
      OPC_REG: begin
        dest      = instr[15:11];
        ctrl.rd_a = 1'b1;
        ctrl.rd_b = 1'b1;
        ctrl.reg_we = 1'b1;
        unique case (fn)
          FN_ADD:  ctrl.op = ALU_ADD;
          FN_SUB:  ctrl.op = ALU_SUB;
          FN_AND:  ctrl.op = ALU_AND;
          FN_OR:   ctrl.op = ALU_OR;
          FN_XOR:  ctrl.op = ALU_XOR;
          FN_SLT:  ctrl.op = ALU_SLT;
          FN_SLL:  ctrl.op = ALU_SLL;
          FN_SRL:  ctrl.op = ALU_SRL;
          FN_SRA:  ctrl.op = ALU_SRA;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OPC_ADDI, OPC_SLTI: begin
        ctrl.op      = (opc == OPC_SLTI) ? ALU_SLT : ALU_ADD;
        ctrl.use_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.rd_a    = 1'b1;
      end
      OPC_ANDI, OPC_ORI, OPC_XORI: begin
        ctrl.op      = (opc == OPC_ANDI) ? ALU_AND :
                       (opc == OPC_ORI)  ? ALU_OR  : ALU_XOR;
        imm          = XLEN'(k16);
        ctrl.use_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.rd_a    = 1'b1;
      end
      OPC_LDW: begin
        ctrl.use_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.is_load = 1'b1;
        ctrl.rd_a    = 1'b1;
      end
      OPC_STW: begin
        ctrl.use_imm  = 1'b1;
        ctrl.is_store = 1'b1;
        ctrl.rd_a     = 1'b1;
        ctrl.rd_b     = 1'b1;
      end
      OPC_BZ, OPC_BNZ: begin
        ctrl.xfer = (opc == OPC_BZ) ? CT_BZ : CT_BNZ;
        ctrl.rd_a = 1'b1;
      end
      OPC_JMP: begin
        ctrl.xfer = CT_JMP;
        imm       = XLEN'($signed(k26));
      end
      default: ;
    endcase
    ctrl.live = valid;
    if (!valid) begin
      ctrl.reg_we   = 1'b0;
      ctrl.is_load  = 1'b0;
      ctrl.is_store = 1'b0;
      ctrl.xfer     = CT_NONE;
      ctrl.rd_a     = 1'b0;
      ctrl.rd_b     = 1'b0;
    end
  end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  localparam int SH_W = $clog2(XLEN);

  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = XLEN'($signed(a) < $signed(b));
      ALU_SLL: y = a << sh;
      ALU_SRL: y = a >> sh;
      ALU_SRA: y = $unsigned($signed(a) >>> sh);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);

  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0)
        rdata[p] = '0;
      else if (we && waddr == raddr[p])
        rdata[p] = wdata;
      else
        rdata[p] = mem[raddr[p]];
    end
  end

endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard
  import pipe5_pkg::*;
(
  input  logic              id_rd_a,
  input  logic              id_rd_b,
  input  logic [RIDX_W-1:0] id_src_a,
  input  logic [RIDX_W-1:0] id_src_b,
  input  logic              ex_load,
  input  logic [RIDX_W-1:0] ex_dest,
  input  logic [RIDX_W-1:0] ex_src_a,
  input  logic [RIDX_W-1:0] ex_src_b,
  input  logic              mem_fwd_ok,
  input  logic [RIDX_W-1:0] mem_dest,
  input  logic              wb_we,
  input  logic [RIDX_W-1:0] wb_dest,
  output logic              stall,
  output fwd_sel_e          fwd_a,
  output fwd_sel_e          fwd_b
);

  function automatic fwd_sel_e pick(input logic [RIDX_W-1:0] src,
                                    input logic m_ok, input logic [RIDX_W-1:0] m_d,
                                    input logic w_ok, input logic [RIDX_W-1:0] w_d);
    if (src == '0)                 return FW_REG;
    else if (m_ok && m_d == src)   return FW_MEM;
    else if (w_ok && w_d == src)   return FW_WB;
    else                           return FW_REG;
  endfunction

  logic ld_live;
  assign ld_live = ex_load && ex_dest != '0;

  assign stall = ld_live &&
                 ((id_rd_a && id_src_a == ex_dest) ||
                  (id_rd_b && id_src_b == ex_dest));

  assign fwd_a = pick(ex_src_a, mem_fwd_ok, mem_dest, wb_we, wb_dest);
  assign fwd_b = pick(ex_src_b, mem_fwd_ok, mem_dest, wb_we, wb_dest);

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [ILEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

  // fetch
  logic [XLEN-1:0] pc;
  logic            stall;
  logic            redirect;

  // fetch -> decode
  logic [ILEN-1:0] ifid_ir;
  logic [XLEN-1:0] ifid_npc;
  logic            ifid_valid;

  // decode
  ctrl_t             id_ctrl;
  logic [RIDX_W-1:0] id_src_a, id_src_b, id_dest;
  logic [XLEN-1:0]   id_imm;
  logic [1:0][RIDX_W-1:0] rf_raddr;
  logic [1:0][XLEN-1:0]   rf_rdata;

  // decode -> execute
  ctrl_t             idex_ctrl;
  logic [XLEN-1:0]   idex_a, idex_b, idex_imm, idex_npc;
  logic [RIDX_W-1:0] idex_src_a, idex_src_b, idex_dest;

  // execute
  fwd_sel_e        fwd_a, fwd_b;
  logic [XLEN-1:0] ex_a, ex_b, ex_alu_b, ex_y, ex_target;
  logic            ex_taken;

  // execute -> memory
  ctrl_t             exmem_ctrl;
  logic [XLEN-1:0]   exmem_y, exmem_sdata, exmem_target;
  logic              exmem_taken;
  logic [RIDX_W-1:0] exmem_dest;

  // memory -> writeback
  logic              memwb_we, memwb_load;
  logic [XLEN-1:0]   memwb_y, memwb_lmd;
  logic [RIDX_W-1:0] memwb_dest;
  logic [XLEN-1:0]   wb_data;

  assign redirect = exmem_ctrl.live && exmem_taken;

  // ---------------- fetch ----------------
  always_ff @(posedge clk) begin
    if (rst)           pc <= RESET_PC;
    else if (redirect) pc <= exmem_target;
    else if (!stall)   pc <= pc + STEP;
  end
  assign imem_addr = pc;

  always_ff @(posedge clk) begin
    if (rst || redirect) begin
      ifid_ir    <= '0;
      ifid_npc   <= '0;
      ifid_valid <= 1'b0;
    end else if (!stall) begin
      ifid_ir    <= imem_rdata;
      ifid_npc   <= pc + STEP;
      ifid_valid <= 1'b1;
    end
  end

  // ---------------- decode ----------------
  pipe5_decode #(.XLEN(XLEN)) u_dec (
    .valid (ifid_valid),
    .instr (ifid_ir),
    .ctrl  (id_ctrl),
    .src_a (id_src_a),
    .src_b (id_src_b),
    .dest  (id_dest),
    .imm   (id_imm)
  );

  assign rf_raddr[0] = id_src_a;
  assign rf_raddr[1] = id_src_b;

  pipe5_regfile #(.XLEN(XLEN), .DEPTH(NREGS), .NRD(2)) u_rf (
    .clk   (clk),
    .we    (memwb_we),
    .waddr (memwb_dest),
    .wdata (wb_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst || redirect || stall) begin
      idex_ctrl  <= '0;
      idex_a     <= '0;
      idex_b     <= '0;
      idex_imm   <= '0;
      idex_npc   <= '0;
      idex_src_a <= '0;
      idex_src_b <= '0;
      idex_dest  <= '0;
    end else begin
      idex_ctrl  <= id_ctrl;
      idex_a     <= rf_rdata[0];
      idex_b     <= rf_rdata[1];
      idex_imm   <= id_imm;
      idex_npc   <= ifid_npc;
      idex_src_a <= id_src_a;
      idex_src_b <= id_src_b;
      idex_dest  <= id_dest;
    end
  end

  // ---------------- hazards ----------------
  pipe5_hazard u_haz (
    .id_rd_a    (id_ctrl.rd_a),
    .id_rd_b    (id_ctrl.rd_b),
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .ex_load    (idex_ctrl.is_load),
    .ex_dest    (idex_dest),
    .ex_src_a   (idex_src_a),
    .ex_src_b   (idex_src_b),
    .mem_fwd_ok (exmem_ctrl.reg_we && !exmem_ctrl.is_load),
    .mem_dest   (exmem_dest),
    .wb_we      (memwb_we),
    .wb_dest    (memwb_dest),
    .stall      (stall),
    .fwd_a      (fwd_a),
    .fwd_b      (fwd_b)
  );

  // ---------------- execute ----------------
  always_comb begin
    unique case (fwd_a)
      FW_MEM:  ex_a = exmem_y;
      FW_WB:   ex_a = wb_data;
      default: ex_a = idex_a;
    endcase
    unique case (fwd_b)
      FW_MEM:  ex_b = exmem_y;
      FW_WB:   ex_b = wb_data;
      default: ex_b = idex_b;
    endcase
  end

  assign ex_alu_b  = idex_ctrl.use_imm ? idex_imm : ex_b;
  assign ex_target = idex_npc + idex_imm;

  always_comb begin
    unique case (idex_ctrl.xfer)
      CT_BZ:   ex_taken = (ex_a == '0);
      CT_BNZ:  ex_taken = (ex_a != '0);
      CT_JMP:  ex_taken = 1'b1;
      default: ex_taken = 1'b0;
    endcase
  end

  pipe5_alu #(.XLEN(XLEN)) u_alu (
    .op (idex_ctrl.op),
    .a  (ex_a),
    .b  (ex_alu_b),
    .y  (ex_y)
  );

  always_ff @(posedge clk) begin
    if (rst || redirect) begin
      exmem_ctrl   <= '0;
      exmem_y      <= '0;
      exmem_sdata  <= '0;
      exmem_target <= '0;
      exmem_taken  <= 1'b0;
      exmem_dest   <= '0;
    end else begin
      exmem_ctrl   <= idex_ctrl;
      exmem_y      <= ex_y;
      exmem_sdata  <= ex_b;
      exmem_target <= ex_target;
      exmem_taken  <= ex_taken;
      exmem_dest   <= idex_dest;
    end
  end

  // ---------------- memory ----------------
  assign dmem_addr  = exmem_y;
  assign dmem_wdata = exmem_sdata;
  assign dmem_we    = exmem_ctrl.is_store;

  always_ff @(posedge clk) begin
    if (rst) begin
      memwb_we   <= 1'b0;
      memwb_load <= 1'b0;
      memwb_y    <= '0;
      memwb_lmd  <= '0;
      memwb_dest <= '0;
    end else begin
      memwb_we   <= exmem_ctrl.reg_we;
      memwb_load <= exmem_ctrl.is_load;
      memwb_y    <= exmem_y;
      memwb_lmd  <= dmem_rdata;
      memwb_dest <= exmem_dest;
    end
  end

  // ---------------- writeback ----------------
  assign wb_data = memwb_load ? memwb_lmd : memwb_y;

endmodule

// File: rtl/pipe5_core_sva.sv
module pipe5_core_sva #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic            dmem_we,
  input logic            stall,
  input logic            redirect,
  input logic [XLEN-1:0] redir_target
);

  // R1: the cycle after reset is released starts at address 0 with no store
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == '0 && !dmem_we));

  // R2: free-running fetch advances by one word
  a_r2_seq_fetch: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redirect) |=> pc == $past(pc) + XLEN'(4));

  // R8: a load-use interlock lasts exactly one cycle
  a_r8_single_bubble: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // R8: fetch address is held during the bubble
  a_r8_hold_pc: assert property (@(posedge clk) disable iff (rst)
    (stall && !redirect) |=> $stable(pc));

  // R10: a taken transfer refetches at its target and squashes the store slot
  a_r10_redirect: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (pc == $past(redir_target) && !dmem_we));

endmodule

bind pipe5_core pipe5_core_sva #(.XLEN(XLEN)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .pc           (imem_addr),
  .dmem_we      (dmem_we),
  .stall        (stall),
  .redirect     (redirect),
  .redir_target (exmem_target)
);

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;

  localparam int NSTORE   = 15;
  localparam int RUN_CYC  = 400;
  localparam int WDOG_CYC = 20000;

  // encodings taken from the requirements
  localparam logic [5:0] O_REG = 6'h00, O_J = 6'h02, O_BZ = 6'h04, O_BNZ = 6'h05;
  localparam logic [5:0] O_ADDI = 6'h08, O_SLTI = 6'h0A, O_ANDI = 6'h0C;
  localparam logic [5:0] O_ORI = 6'h0D, O_XORI = 6'h0E, O_LW = 6'h23, O_SW = 6'h2B;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_XOR = 6'h26, F_SLT = 6'h2A;
  localparam logic [5:0] F_SLL = 6'h04, F_SRL = 6'h06, F_SRA = 6'h07;

  // expected value of the k-th store (to byte address 4*k) and its requirement
  localparam logic [31:0] EXP_VAL [NSTORE] = '{
    32'h0000_0002,  // R3 add, R6 forward
    32'h0000_0008,  // R3 sub, R6 forward
    32'h0000_0000,  // R5 register 0
    32'h0000_0007,  // R8 load then ALU use
    32'h0000_000A,  // R3 shift left
    32'hFFFF_FFFE,  // R3 arithmetic shift
    32'h7FFF_FFFE,  // R3 logical shift
    32'hFFFF_FFF8,  // R3 xor
    32'h0000_F0F0,  // R4 zero-extended and
    32'h0000_0001,  // R4 signed compare immediate
    32'h0000_1234,  // R4 or immediate
    32'h0000_0005,  // R9 branch not taken
    32'h0000_000F,  // R9 loop branch
    32'h0000_0008,  // R7 load then store of it
    32'h0000_000F   // R8 load then branch on it
  };
  localparam int EXP_TAG [NSTORE] = '{6, 6, 5, 8, 3, 3, 3, 3, 4, 4, 4, 9, 9, 7, 8};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] store_log [64];
  int          store_cnt;
  int          poison_cnt;
  int          tests = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  pipe5_core dut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) dmem[i] <= '0;
      store_cnt  <= 0;
      poison_cnt <= 0;
    end else if (dmem_we) begin
      if (dmem_addr >= 32'd256) poison_cnt <= poison_cnt + 1;
      else dmem[dmem_addr[7:2]] <= dmem_wdata;
      if (store_cnt < 64) store_log[store_cnt] <= dmem_addr;
      store_cnt <= store_cnt + 1;
    end
  end

  function automatic logic [31:0] rr(logic [5:0] fn, int rd, int ra, int rb);
    return {O_REG, 5'(ra), 5'(rb), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] ii(logic [5:0] op, int rt, int ra, int k);
    return {op, 5'(ra), 5'(rt), 16'(k)};
  endfunction
  function automatic logic [31:0] jj(int off);
    return {O_J, 26'(off)};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < 64; i++) imem[i] = '0;
    imem[0]  = ii(O_ADDI, 1, 0, 5);
    imem[1]  = ii(O_ADDI, 2, 0, -3);
    imem[2]  = rr(F_ADD, 3, 1, 2);
    imem[3]  = rr(F_SUB, 4, 1, 2);
    imem[4]  = ii(O_SW, 3, 0, 0);
    imem[5]  = ii(O_SW, 4, 0, 4);
    imem[6]  = ii(O_ADDI, 0, 0, 7);
    imem[7]  = ii(O_SW, 0, 0, 8);
    imem[8]  = ii(O_LW, 5, 0, 0);
    imem[9]  = rr(F_ADD, 6, 5, 1);
    imem[10] = ii(O_SW, 6, 0, 12);
    imem[11] = rr(F_SLT, 7, 2, 1);
    imem[12] = rr(F_SLL, 8, 1, 7);
    imem[13] = rr(F_SRA, 9, 2, 7);
    imem[14] = rr(F_SRL, 10, 2, 7);
    imem[15] = ii(O_SW, 8, 0, 16);
    imem[16] = ii(O_SW, 9, 0, 20);
    imem[17] = ii(O_SW, 10, 0, 24);
    imem[18] = rr(F_XOR, 13, 1, 2);
    imem[19] = ii(O_ANDI, 14, 13, 16'hF0F0);
    imem[20] = ii(O_SW, 13, 0, 28);
    imem[21] = ii(O_SW, 14, 0, 32);
    imem[22] = ii(O_SLTI, 15, 2, -2);
    imem[23] = ii(O_ORI, 16, 0, 16'h1234);
    imem[24] = ii(O_SW, 15, 0, 36);
    imem[25] = ii(O_SW, 16, 0, 40);
    imem[26] = ii(O_BZ, 0, 0, 8);       // R9 taken, R10 skips two poison stores
    imem[27] = ii(O_SW, 1, 0, 256);
    imem[28] = ii(O_SW, 1, 0, 256);
    imem[29] = ii(O_BNZ, 0, 0, 4);      // not taken
    imem[30] = ii(O_SW, 1, 0, 44);
    imem[31] = ii(O_ADDI, 11, 0, 3);
    imem[32] = ii(O_ADDI, 12, 0, 0);
    imem[33] = rr(F_ADD, 12, 12, 1);
    imem[34] = ii(O_ADDI, 11, 11, -1);
    imem[35] = ii(O_BNZ, 0, 11, -12);   // loop back to 33
    imem[36] = ii(O_SW, 12, 0, 48);
    imem[37] = jj(8);                   // R11 jump over poison
    imem[38] = ii(O_SW, 1, 0, 256);
    imem[39] = ii(O_SW, 1, 0, 256);
    imem[40] = ii(O_LW, 17, 0, 4);
    imem[41] = ii(O_SW, 17, 0, 52);
    imem[42] = ii(O_LW, 18, 0, 48);
    imem[43] = ii(O_BZ, 0, 18, 4);      // must not be taken
    imem[44] = ii(O_SW, 18, 0, 56);
    imem[45] = jj(-4);                  // spin on itself
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin : watchdog
    repeat (WDOG_CYC) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R2 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin : main
    load_program();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "fetch address in reset", imem_addr, 32'h0);
    check("R1", "store strobe in reset", {31'd0, dmem_we}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", "first fetch step", imem_addr, 32'h4);
    @(negedge clk);
    check("R2", "second fetch step", imem_addr, 32'h8);

    repeat (RUN_CYC) @(negedge clk);

    for (int k = 0; k < NSTORE; k++) begin
      check($sformatf("R%0d", EXP_TAG[k]), $sformatf("store %0d address", k),
            store_log[k], 32'(4 * k));
      check($sformatf("R%0d", EXP_TAG[k]), $sformatf("store %0d value", k),
            dmem[k], EXP_VAL[k]);
    end

    // R10: every instruction behind a taken transfer is squashed
    check("R10", "stores to poison address", 32'(poison_cnt), 32'h0);
    check("R10", "total store count", 32'(store_cnt), 32'(NSTORE));
    // R11: the final self-jump keeps fetch inside its four-word window
    check("R11", "spin window", {31'd0, (imem_addr >= 32'd180 && imem_addr <= 32'd192)}, 32'h1);

    summary();
    $finish;
  end

endmodule